// File: doc/BRIEF.md
# Bus Controller Intermessage Gap Timer

This block times the idle interval that a command/response serial bus controller leaves between one message and the next. When a message finishes, the timer starts counting. It divides the system clock into 1 µs ticks using a selectable cycles-per-microsecond ratio. It waits either a fixed minimum gap or a host-programmed gap, adds a fixed cycle surcharge when enhanced controller mode is on, and then emits a one-cycle pulse that starts the next message.

Host accesses can collide with the controller's internal start-of-message and end-of-message transfer slots. Each such collision lengthens the gap by a fixed penalty, but only while the penalty option is enabled and the gap is running. The number of penalised accesses per gap is capped. This matches the twelve internal slots: seven at start of message and five at end of message.

Top module: `imgap_timer`

## Requirements
- R1: After reset, `start_pulse` is 0 and stays 0 until a `msg_done` strobe has been followed by a complete gap.
- R2: `clk_sel` picks the tick length in clock cycles: 0 gives 10, 1 gives 12, 2 gives 16 and 3 gives 20.
- R3: With no surcharge, `start_pulse` goes high after rising edge number G·C+1. Edges are counted from the edge that samples `msg_done`, which is edge 0. G is `gap_us`, or 10 when `gap_us` is 0, and C is the tick length.
- R4: When `enh_mode` is 1 at the `msg_done` edge, the gap is 10 cycles longer.
- R5: Each edge at which all of the following hold lengthens the gap by 6 cycles: the gap is running, `penalty_en` is 1, `host_acc` is 1, and `som_slot` or `eom_slot` is 1. An access that misses any of these conditions adds nothing.
- R6: At most 12 penalties are counted per gap, so collisions add no more than 72 cycles.
- R7: `start_pulse` lasts exactly one cycle and is never raised while any penalty cycle remains. A penalty taken in the last cycles of a gap still delays the pulse by a full 6 cycles.
- R8: A `msg_done` strobe during a running gap restarts the gap from that edge and clears the penalty count. A host access on that same edge is not penalised.
- R9: `clk_sel`, `gap_us` and `enh_mode` are sampled only at the `msg_done` edge. Later changes do not affect the running gap.
- R10: Host accesses while no gap is running add nothing to the next gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clk_sel | input | 2 | Clock-rate select (cycles per µs) |
| enh_mode | input | 1 | Enhanced controller mode, adds the fixed surcharge |
| gap_us | input | 16 | Programmed gap in µs, 0 selects the minimum |
| msg_done | input | 1 | One-cycle strobe at message end, starts the gap |
| host_acc | input | 1 | One-cycle strobe per host access |
| penalty_en | input | 1 | Enables collision penalties |
| som_slot | input | 1 | A start-of-message internal transfer slot is active |
| eom_slot | input | 1 | An end-of-message internal transfer slot is active |
| start_pulse | output | 1 | One-cycle pulse that starts the next message |

## Verification
The assertions take `msg_done` and `host_acc` to be single-cycle strobes that are synchronous to `clk`. They also take `msg_done` to be spaced wider than one tick, which keeps the single-pulse and no-pulse-after-load properties meaningful. The stimulus raises each strobe for one cycle at a falling edge, holds `clk_sel` at legal codes, and starts each gap only after the previous pulse or as a deliberate restart. Penalty bursts are placed both inside the microsecond phase and in the final surcharge cycles, so that the hold-off of the pulse is exercised at the boundary.

// File: rtl/imgap_timer.sv
module imgap_timer #(
  parameter int GAP_W      = 16,
  parameter int MIN_GAP_US = 10,
  parameter int ENH_EXTRA  = 10,
  parameter int PEN_CYC    = 6,
  parameter int MAX_PEN    = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       clk_sel,
  input  logic             enh_mode,
  input  logic [GAP_W-1:0] gap_us,
  input  logic             msg_done,
  input  logic             host_acc,
  input  logic             penalty_en,
  input  logic             som_slot,
  input  logic             eom_slot,
  output logic             start_pulse
);
  localparam int EXTRA_MAX = ENH_EXTRA + PEN_CYC * MAX_PEN;
  localparam int EXW = $clog2(EXTRA_MAX + 1);
  localparam int PNW = $clog2(MAX_PEN + 1);

  logic             busy;
  logic [4:0]       pre, tick_m1;
  logic [GAP_W-1:0] us_left;
  logic [EXW-1:0]   extra, extra_n;
  logic [PNW-1:0]   pen_n;
  logic             acc;
  logic [4:0]       sel_m1;

  always_comb begin
    case (clk_sel)
      2'd0:    sel_m1 = 5'd9;
      2'd1:    sel_m1 = 5'd11;
      2'd2:    sel_m1 = 5'd15;
      default: sel_m1 = 5'd19;
    endcase
  end

  assign acc = busy & ~msg_done & penalty_en & host_acc & (som_slot | eom_slot)
             & (pen_n != PNW'(MAX_PEN));
  assign extra_n = extra + (acc ? EXW'(PEN_CYC) : '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy        <= 1'b0;
      pre         <= '0;
      tick_m1     <= '0;
      us_left     <= '0;
      extra       <= '0;
      pen_n       <= '0;
      start_pulse <= 1'b0;
    end else begin
      start_pulse <= 1'b0;
      if (msg_done) begin
        busy    <= 1'b1;
        tick_m1 <= sel_m1;
        pre     <= sel_m1;
        us_left <= (gap_us == '0) ? GAP_W'(MIN_GAP_US) : gap_us;
        extra   <= enh_mode ? EXW'(ENH_EXTRA) : '0;
        pen_n   <= '0;
      end else if (busy) begin
        if (acc) pen_n <= pen_n + 1'b1;
        if (us_left != '0) begin
          extra <= extra_n;
          if (pre == '0) begin
            pre     <= tick_m1;
            us_left <= us_left - 1'b1;
          end else begin
            pre <= pre - 1'b1;
          end
        end else if (extra_n != '0) begin
          extra <= extra_n - 1'b1;
        end else begin
          busy        <= 1'b0;
          start_pulse <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/imgap_timer_chk.sv
module imgap_timer_chk #(
  parameter int PNW     = 4,
  parameter int MAX_PEN = 12
) (
  input logic           clk,
  input logic           rst_n,
  input logic           msg_done,
  input logic           start_pulse,
  input logic           busy,
  input logic [4:0]     pre,
  input logic [4:0]     tick_m1,
  input logic [PNW-1:0] pen_n
);
  AST_PULSE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    start_pulse |=> !start_pulse); // R7
  AST_NO_PULSE_AT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    msg_done |=> !start_pulse); // R8
  AST_PULSE_FROM_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    start_pulse |-> $past(busy)); // R1
  AST_PEN_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    pen_n <= PNW'(MAX_PEN)); // R6
  AST_TICK_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> pre <= tick_m1); // R2
endmodule

bind imgap_timer imgap_timer_chk #(.PNW(PNW), .MAX_PEN(MAX_PEN)) chk_i (
  .clk(clk), .rst_n(rst_n), .msg_done(msg_done), .start_pulse(start_pulse),
  .busy(busy), .pre(pre), .tick_m1(tick_m1), .pen_n(pen_n));

// File: tb/imgap_timer_tb.sv
module imgap_timer_tb_top;
  logic clk = 0, rst_n = 0;
  logic [1:0] clk_sel = 0;
  logic enh_mode = 0, msg_done = 0, host_acc = 0, penalty_en = 0, som_slot = 0, eom_slot = 0;
  logic [15:0] gap_us = 0;
  logic start_pulse;
  int checks = 0, fails = 0;
  string cur_req = "R1";
  bit done = 0;

  always #2.5 clk = ~clk;

  imgap_timer dut_i (.clk(clk), .rst_n(rst_n), .clk_sel(clk_sel), .enh_mode(enh_mode),
    .gap_us(gap_us), .msg_done(msg_done), .host_acc(host_acc), .penalty_en(penalty_en),
    .som_slot(som_slot), .eom_slot(eom_slot), .start_pulse(start_pulse));

  // behavioural reference: remaining cycles to the pulse
  int rem = 0, pens = 0;
  bit mbusy = 0, exp_pulse = 0;
  function automatic int cyc_of(input logic [1:0] s);
    int t[4] = '{10, 12, 16, 20};
    return t[s];
  endfunction
  always @(posedge clk) begin
    if (!rst_n) begin
      mbusy = 0; exp_pulse = 0; rem = 0; pens = 0;
    end else begin
      exp_pulse = 0;
      if (msg_done) begin
        mbusy = 1; pens = 0;
        rem = ((gap_us == 0) ? 10 : int'(gap_us)) * cyc_of(clk_sel) + (enh_mode ? 10 : 0);
      end else if (mbusy) begin
        if (penalty_en && host_acc && (som_slot || eom_slot) && pens < 12) begin
          rem += 6; pens++;
        end
        if (rem == 0) begin exp_pulse = 1; mbusy = 0; end
        else rem--;
      end
    end
  end

  always @(negedge clk) if (rst_n && !done) begin
    checks++;
    if (start_pulse !== exp_pulse) begin
      fails++;
      $display("FAIL %s cycle compare: actual %0b expected %0b", cur_req, start_pulse, exp_pulse);
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // strobe msg_done, apply n_acc accesses from offset acc_at, return edges to pulse
  task automatic run_gap(input int n_acc, input int acc_at, input bit slot, output int k);
    msg_done = 1;
    @(negedge clk); msg_done = 0;
    k = 0;
    while (!start_pulse && k < 5000) begin
      host_acc = (k >= acc_at && k < acc_at + n_acc);
      som_slot = slot && host_acc;
      @(negedge clk); k++;
    end
    host_acc = 0; som_slot = 0;
  endtask

  int k;
  initial begin
    repeat (3) @(negedge clk);
    cur_req = "R1";
    check("R1 reset pulse", start_pulse, 0);
    rst_n = 1;
    repeat (20) @(negedge clk);
    check("R1 idle pulse", start_pulse, 0);

    for (int s = 0; s < 4; s++) begin
      cur_req = "R2";
      clk_sel = s[1:0]; gap_us = 3;
      run_gap(0, 0, 0, k);
      check("R2 tick length", k, 3 * cyc_of(s[1:0]) + 1);
      @(negedge clk);
      check("R7 one-cycle pulse", start_pulse, 0);
    end

    cur_req = "R3"; clk_sel = 0; gap_us = 0;
    run_gap(0, 0, 0, k); check("R3 minimum gap", k, 101);
    gap_us = 7; clk_sel = 2;
    run_gap(0, 0, 0, k); check("R3 programmed gap", k, 113);

    cur_req = "R4"; enh_mode = 1; clk_sel = 1; gap_us = 2;
    run_gap(0, 0, 0, k); check("R4 enhanced surcharge", k, 35);
    enh_mode = 0;

    cur_req = "R5"; penalty_en = 1; clk_sel = 0; gap_us = 2;
    run_gap(3, 4, 1, k); check("R5 three penalties", k, 21 + 18);
    run_gap(3, 4, 0, k); check("R5 no slot no penalty", k, 21);
    penalty_en = 0;
    run_gap(3, 4, 1, k); check("R5 option off", k, 21);
    penalty_en = 1; eom_slot = 1;
    run_gap(1, 2, 0, k); check("R5 end-of-message slot", k, 27);
    eom_slot = 0;

    cur_req = "R6";
    run_gap(15, 1, 1, k); check("R6 penalty cap", k, 21 + 72);

    cur_req = "R7";
    run_gap(2, 20, 1, k); check("R7 late penalty hold-off", k, 21 + 12);
    @(negedge clk); check("R7 single pulse", start_pulse, 0);

    cur_req = "R8";
    msg_done = 1; @(negedge clk); msg_done = 0;
    repeat (5) @(negedge clk);
    som_slot = 1; host_acc = 1;
    run_gap(0, 0, 0, k); check("R8 restart ignores same-edge access", k, 21);

    cur_req = "R9"; clk_sel = 0; gap_us = 4;
    msg_done = 1; @(negedge clk); msg_done = 0;
    k = 0;
    clk_sel = 3; gap_us = 100; enh_mode = 1;
    while (!start_pulse && k < 5000) begin @(negedge clk); k++; end
    check("R9 inputs sampled at start", k, 41);
    enh_mode = 0;

    cur_req = "R10"; clk_sel = 0; gap_us = 1;
    som_slot = 1;
    repeat (4) begin host_acc = 1; @(negedge clk); host_acc = 0; @(negedge clk); end
    som_slot = 0;
    check("R10 idle access no pulse", start_pulse, 0);
    run_gap(0, 0, 0, k); check("R10 idle access ignored", k, 11);

    repeat (3) @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #500000;
    done = 1;
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule